// File: doc/BRIEF.md
# Bit-Serial BCH Syndrome Generator

This block computes the syndromes of a received binary BCH codeword over GF(2^13). The codeword arrives as 16-bit words through a valid/ready handshake. A small word-to-bit serializer hands the bits, most significant first, to a syndrome core. The core advances by one bit per clock, so its logic stays small while the input interface stays wide.

The correction capability t is chosen per block and sampled together with the start-of-block marker. The codeword length is the data length (a parameter, 4096 bits by default) plus 13·t parity bits. Only the odd syndromes are accumulated. The even ones are formed by repeated squaring once the block is complete.

A one-cycle done strobe marks the end of a block. A zero flag reports that every syndrome of that block is zero, which means the block is error-free. A synchronous abort returns the block to its idle state without using the reset.

Top module: `bch_syn_gen`

## Requirements
- R1: The serializer accepts a word only when `ready_o` is high. `ready_o` is high exactly when the serializer holds at most one unconsumed bit. After an accepted word of 16 used bits, `ready_o` is low for 15 cycles and one bit is consumed per cycle.
- R2: After a block, syndrome field j (1 ≤ j ≤ 2t) at `syn_o[(j-1)*13 +: 13]` equals r(α^j). Here r(x) is the received polynomial whose first received bit is the highest-degree coefficient. Bits are taken from bit 15 down to bit 0 of each word. α is a root of x^13+x^4+x^3+x+1, and field elements use a polynomial basis with bit 0 as the constant term.
- R3: A block is n = K + 13·t bits long, which takes ceil(n/16) words. In a partial final word only the upper (n mod 16) bits are used, and its lower bits have no effect on the syndromes.
- R4: t is taken from `t_sel_i` in the cycle the start word is accepted. A value of 0 or above T_MAX (8) selects T_MAX. Syndrome fields above 2t read as zero.
- R5: `done_o` is high for exactly one cycle, in the cycle after the final codeword bit is consumed.
- R6: `zero_o` is high only while a completed result is held and all 2t syndromes of that result are zero. It is low after reset and while a block is being received.
- R7: `syn_o` and `zero_o` hold their values from `done_o` until the first bit of the next block is consumed. A following block may be offered back-to-back, with its start word accepted in the same cycle as the previous block's last bit.
- R8: While `abort_i` is high, no word is accepted. The serializer, the block count, the syndromes, the result and the done strobe all return to their reset state on the next edge. An aborted block never raises `done_o`.
- R9: A word without `sob_i` offered while no block is open is consumed and ignored. A word with `sob_i` accepted while a block is open abandons that block and starts a new one.
- R10: During reset `ready_o` is 1, and `done_o`, `zero_o` and `syn_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous return to idle |
| word_vld_i | input | 1 | Input word valid |
| sob_i | input | 1 | Word is the first of a block |
| word_i | input | 16 | Codeword bits, bit 15 first |
| t_sel_i | input | 4 | Correction capability for the block |
| ready_o | output | 1 | Word can be accepted |
| syn_o | output | 208 | Syndromes S1..S16, 13 bits each |
| done_o | output | 1 | One-cycle end-of-block strobe |
| zero_o | output | 1 | All syndromes of held result are zero |

## Verification
Two events can fall on the same clock edge: the consumption of a block's last bit and the acceptance of the next block's start word. The bench provokes this by offering the next start word with no idle gap, and it judges the result by the done strobe and held syndromes of the first block together with the correct result of the second. The same edge is also shared by an abort and a pending last bit, which the bench arranges by asserting abort exactly when one final bit remains. It then expects no done strobe. A behavioural model predicts the handshake, the strobe, the flag and every syndrome field on each cycle.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;

  localparam int unsigned GF_M = 13;
  typedef logic [GF_M-1:0] gf_t;
  // x^13 + x^4 + x^3 + x + 1, leading term implied
  localparam gf_t GF_RED = 13'h001B;

  function automatic gf_t gf_xtime(gf_t a);
    gf_t r;
    r = {a[GF_M-2:0], 1'b0};
    if (a[GF_M-1]) r = r ^ GF_RED;
    return r;
  endfunction

  function automatic gf_t gf_mul_apow(gf_t a, int unsigned k);
    gf_t r;
    r = a;
    for (int unsigned i = 0; i < k; i++) r = gf_xtime(r);
    return r;
  endfunction

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t r;
    r = '0;
    for (int i = GF_M - 1; i >= 0; i--) begin
      r = gf_xtime(r);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic gf_t gf_sq_n(gf_t a, int unsigned e);
    gf_t r;
    r = a;
    for (int unsigned i = 0; i < e; i++) r = gf_mul(r, r);
    return r;
  endfunction

  function automatic int unsigned odd_part(int unsigned j);
    int unsigned v;
    v = j;
    while (v != 0 && v % 2 == 0) v = v / 2;
    return v;
  endfunction

  function automatic int unsigned two_exp(int unsigned j);
    int unsigned v;
    int unsigned e;
    v = j;
    e = 0;
    while (v != 0 && v % 2 == 0) begin
      v = v / 2;
      e++;
    end
    return e;
  endfunction

endpackage

// File: rtl/bch_syn_ser.sv
module bch_syn_ser
  import bch_syn_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned K_BITS = 4096,
  parameter int unsigned T_MAX  = 8,
  parameter int unsigned TW     = $clog2(T_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          word_vld_i,
  input  logic          sob_i,
  input  logic [W-1:0]  word_i,
  input  logic [TW-1:0] t_sel_i,
  output logic          ready_o,
  output logic          bit_o,
  output logic          bit_vld_o,
  output logic          bit_first_o,
  output logic          bit_last_o,
  output logic [TW-1:0] t_o
);

  localparam int unsigned CW   = $clog2(W + 1);
  localparam int unsigned NMAX = K_BITS + GF_M * T_MAX;
  localparam int unsigned NW   = $clog2(NMAX + 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic [NW-1:0] blk_q;
  logic          first_q;
  logic          lastw_q;
  logic [TW-1:0] t_q;

  logic [TW-1:0] t_eff;
  logic [NW-1:0] n_new;
  logic [NW-1:0] avail;
  logic [CW-1:0] load;
  logic          take;

  always_comb begin
    t_eff = t_sel_i;
    if (t_sel_i == '0 || int'(t_sel_i) > int'(T_MAX)) t_eff = TW'(T_MAX);
    n_new = NW'(K_BITS + GF_M * int'(t_eff));
    avail = sob_i ? n_new : blk_q;
    load  = (avail >= NW'(W)) ? CW'(W) : CW'(avail);
  end

  assign ready_o = (cnt_q <= CW'(1));
  // idle words without a start marker are swallowed
  assign take = word_vld_i && ready_o && !abort_i && (sob_i || blk_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      blk_q   <= '0;
      first_q <= 1'b0;
      lastw_q <= 1'b0;
      t_q     <= TW'(T_MAX);
    end else if (abort_i) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      blk_q   <= '0;
      first_q <= 1'b0;
      lastw_q <= 1'b0;
      t_q     <= TW'(T_MAX);
    end else if (take) begin
      sh_q    <= word_i;
      cnt_q   <= load;
      blk_q   <= avail - NW'(load);
      first_q <= sob_i;
      lastw_q <= (avail == NW'(load));
      if (sob_i) t_q <= t_eff;
    end else if (cnt_q != '0) begin
      sh_q    <= {sh_q[W-2:0], 1'b0};
      cnt_q   <= cnt_q - CW'(1);
      first_q <= 1'b0;
    end
  end

  assign bit_o       = sh_q[W-1];
  assign bit_vld_o   = (cnt_q != '0);
  assign bit_first_o = first_q;
  assign bit_last_o  = lastw_q && (cnt_q == CW'(1));
  assign t_o         = t_q;

  AST_DRAIN_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > CW'(1) && !abort_i) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R1

  AST_ABORT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (cnt_q == '0 && blk_q == '0)); // R8

endmodule

// File: rtl/bch_syn_core.sv
module bch_syn_core
  import bch_syn_pkg::*;
#(
  parameter int unsigned T_MAX = 8,
  parameter int unsigned TW    = $clog2(T_MAX + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  abort_i,
  input  logic                  bit_i,
  input  logic                  bit_vld_i,
  input  logic                  bit_first_i,
  input  logic                  bit_last_i,
  input  logic [TW-1:0]         t_i,
  output gf_t [T_MAX-1:0]       odd_o,
  output logic                  res_vld_o,
  output logic [TW-1:0]         t_res_o,
  output logic                  done_o
);

  gf_t [T_MAX-1:0] s_q;
  gf_t [T_MAX-1:0] s_nxt;
  logic            res_vld_q;
  logic            done_q;
  logic [TW-1:0]   t_res_q;

  // S(2g+1) <= S*alpha^(2g+1) ^ bit; the first bit of a block overwrites
  for (genvar g = 0; g < int'(T_MAX); g++) begin : g_odd
    localparam int unsigned PW = 2 * g + 1;
    assign s_nxt[g] = bit_first_i ? gf_t'(bit_i)
                                  : (gf_mul_apow(s_q[g], PW) ^ gf_t'(bit_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q       <= '0;
      res_vld_q <= 1'b0;
      done_q    <= 1'b0;
      t_res_q   <= TW'(T_MAX);
    end else if (abort_i) begin
      s_q       <= '0;
      res_vld_q <= 1'b0;
      done_q    <= 1'b0;
      t_res_q   <= TW'(T_MAX);
    end else begin
      done_q <= bit_vld_i && bit_last_i;
      if (bit_vld_i) begin
        s_q <= s_nxt;
        if (bit_first_i) begin
          res_vld_q <= 1'b0;
          t_res_q   <= t_i;
        end
        if (bit_last_i) res_vld_q <= 1'b1;
      end
    end
  end

  assign odd_o     = s_q;
  assign res_vld_o = res_vld_q;
  assign t_res_o   = t_res_q;
  assign done_o    = done_q;

  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_q && !bit_vld_i && !abort_i) |=> $stable(s_q)); // R7

endmodule

// File: rtl/bch_syn_fold.sv
module bch_syn_fold
  import bch_syn_pkg::*;
#(
  parameter int unsigned T_MAX = 8,
  parameter int unsigned TW    = $clog2(T_MAX + 1)
) (
  input  gf_t [T_MAX-1:0]           odd_i,
  input  logic                      res_vld_i,
  input  logic [TW-1:0]             t_i,
  output logic [2*T_MAX*GF_M-1:0]   syn_o,
  output logic                      zero_o
);

  // S(o*2^e) = S(o)^(2^e) for binary codes
  for (genvar j = 1; j <= int'(2 * T_MAX); j++) begin : g_syn
    localparam int unsigned OP = odd_part(j);
    localparam int unsigned EX = two_exp(j);
    gf_t val;
    assign val = gf_sq_n(odd_i[(OP-1)/2], EX);
    assign syn_o[(j-1)*GF_M +: GF_M] = (j <= 2 * int'(t_i)) ? val : '0;
  end

  logic any_nz;
  always_comb begin
    any_nz = 1'b0;
    for (int g = 0; g < int'(T_MAX); g++)
      if (g < int'(t_i) && odd_i[g] != '0) any_nz = 1'b1;
  end

  assign zero_o = res_vld_i && !any_nz;

endmodule

// File: rtl/bch_syn_gen.sv
module bch_syn_gen
  import bch_syn_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned K_BITS = 4096,
  parameter int unsigned T_MAX  = 8,
  parameter int unsigned TW     = $clog2(T_MAX + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     abort_i,
  input  logic                     word_vld_i,
  input  logic                     sob_i,
  input  logic [W-1:0]             word_i,
  input  logic [TW-1:0]            t_sel_i,
  output logic                     ready_o,
  output logic [2*T_MAX*GF_M-1:0]  syn_o,
  output logic                     done_o,
  output logic                     zero_o
);

  logic            bit_w;
  logic            bit_vld;
  logic            bit_first;
  logic            bit_last;
  logic [TW-1:0]   t_blk;
  logic [TW-1:0]   t_res;
  logic            res_vld;
  gf_t [T_MAX-1:0] odd;

  bch_syn_ser #(.W(W), .K_BITS(K_BITS), .T_MAX(T_MAX), .TW(TW)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (abort_i),
    .word_vld_i (word_vld_i),
    .sob_i      (sob_i),
    .word_i     (word_i),
    .t_sel_i    (t_sel_i),
    .ready_o    (ready_o),
    .bit_o      (bit_w),
    .bit_vld_o  (bit_vld),
    .bit_first_o(bit_first),
    .bit_last_o (bit_last),
    .t_o        (t_blk)
  );

  bch_syn_core #(.T_MAX(T_MAX), .TW(TW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (abort_i),
    .bit_i      (bit_w),
    .bit_vld_i  (bit_vld),
    .bit_first_i(bit_first),
    .bit_last_i (bit_last),
    .t_i        (t_blk),
    .odd_o      (odd),
    .res_vld_o  (res_vld),
    .t_res_o    (t_res),
    .done_o     (done_o)
  );

  bch_syn_fold #(.T_MAX(T_MAX), .TW(TW)) u_fold (
    .odd_i    (odd),
    .res_vld_i(res_vld),
    .t_i      (t_res),
    .syn_o    (syn_o),
    .zero_o   (zero_o)
  );

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

  AST_ZERO_RISE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(zero_o) |-> done_o); // R6

  AST_READY_AFTER_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> ready_o); // R8

endmodule

// File: tb/bch_syn_gen_tb_top.sv
module bch_syn_gen_tb_top;

  localparam int KB = 4096;
  localparam int TM = 8;
  localparam int GM = 13;
  localparam int NS = 2 * TM;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          abort = 1'b0;
  logic          wvld = 1'b0;
  logic          sob = 1'b0;
  logic [15:0]   word = '0;
  logic [3:0]    tsel = '0;
  logic          ready;
  logic [NS*GM-1:0] syn;
  logic          done;
  logic          zero;

  always #5 clk = ~clk;

  bch_syn_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .abort_i(abort), .word_vld_i(wvld),
    .sob_i(sob), .word_i(word), .t_sel_i(tsel), .ready_o(ready),
    .syn_o(syn), .done_o(done), .zero_o(zero)
  );

  int errors = 0;
  int checks = 0;
  int cyc_n = 0;
  int n_done = 0;
  int blk_words = 0;
  bit last_acc = 0;

  // model state
  int m_sh = 0, m_blk = 0;
  bit m_first = 0, m_lastw = 0, m_res = 0, m_done = 0;
  int mt_cur = TM, mt_res = TM;
  int es [1:NS];
  int apow [1:NS];
  bit q [$];

  function automatic int bm_mul(int a, int b);
    int r = 0;
    for (int i = 0; i < GM; i++) if (((b >> i) & 1) == 1) r = r ^ (a << i);
    for (int k = 2 * GM - 2; k >= GM; k--)
      if (((r >> k) & 1) == 1) r = r ^ ('h201B << (k - GM));
    return r;
  endfunction

  function automatic int t_eff(int t);
    return (t == 0 || t > TM) ? TM : t;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d (cycle %0d)", req, what, act, exp, cyc_n);
    end
  endtask

  task automatic compare();
    bit ez;
    chk(ready === (m_sh <= 1), "R1", "ready_o", int'(ready), int'(m_sh <= 1));
    chk(done === m_done, "R5", "done_o", int'(done), int'(m_done));
    ez = m_res;
    for (int j = 1; j <= 2 * mt_res; j++) if (es[j] != 0) ez = 0;
    chk(zero === ez, "R6", "zero_o", int'(zero), int'(ez));
    if (m_res) begin
      for (int j = 1; j <= NS; j++) begin
        int ex;
        ex = (j <= 2 * mt_res) ? es[j] : 0;
        chk(int'(syn[(j-1)*GM +: GM]) == ex, "R2", $sformatf("syn field %0d", j),
            int'(syn[(j-1)*GM +: GM]), ex);
      end
    end
  endtask

  task automatic cyc(bit v, bit s, logic [15:0] w, int t, bit ab);
    bit acc;
    wvld = v; sob = s; word = w; tsel = t[3:0]; abort = ab;
    acc = v && (m_sh <= 1) && !ab;
    m_done = 0;
    if (ab) begin
      m_sh = 0; m_blk = 0; m_first = 0; m_lastw = 0; m_res = 0;
      mt_cur = TM; mt_res = TM; q.delete();
      for (int j = 1; j <= NS; j++) es[j] = 0;
    end else begin
      if (m_sh > 0) begin
        bit b;
        b = q.pop_front();
        if (m_first) begin
          mt_res = mt_cur; m_res = 0;
          for (int j = 1; j <= NS; j++) es[j] = int'(b);
        end else begin
          for (int j = 1; j <= NS; j++) es[j] = bm_mul(es[j], apow[j]) ^ int'(b);
        end
        if (m_sh == 1 && m_lastw) begin
          m_done = 1; m_res = 1;
        end
        m_first = 0;
        m_sh--;
      end
      if (acc && (s || m_blk > 0)) begin
        int avail, load;
        avail = s ? (KB + GM * t_eff(t)) : m_blk;
        load = (avail >= 16) ? 16 : avail;
        for (int i = 0; i < load; i++) q.push_back(w[15 - i]);
        m_sh = load; m_blk = avail - load; m_first = s; m_lastw = (m_blk == 0);
        if (s) mt_cur = t_eff(t);
      end
    end
    last_acc = acc;
    @(posedge clk);
    @(negedge clk);
    cyc_n++;
    if (done === 1'b1) n_done++;
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 16'h0, 0, 0);
  endtask

  task automatic send_block(int t, bit zero_data, int max_words);
    int nw;
    nw = (KB + GM * t_eff(t) + 15) / 16;
    if (max_words >= 0 && max_words < nw) nw = max_words;
    blk_words = 0;
    for (int i = 0; i < nw; i++) begin
      logic [15:0] w;
      w = zero_data ? 16'h0 : 16'($urandom());
      do cyc(1, i == 0, w, t, 0); while (!last_acc);
      blk_words++;
    end
  endtask

  task automatic wait_done();
    int k = 0;
    while (done !== 1'b1 && k < 20000) begin
      idle(1);
      k++;
    end
  endtask

  initial begin
    int nd;
    logic [NS*GM-1:0] cap;
    apow[1] = 2;
    for (int j = 2; j <= NS; j++) apow[j] = bm_mul(apow[j-1], 2);
    for (int j = 1; j <= NS; j++) es[j] = 0;

    repeat (3) @(negedge clk);
    chk(ready === 1'b1, "R10", "ready_o in reset", int'(ready), 1);
    chk(done === 1'b0, "R10", "done_o in reset", int'(done), 0);
    chk(zero === 1'b0, "R10", "zero_o in reset", int'(zero), 0);
    chk(syn == '0, "R10", "syn_o in reset", int'(syn != '0), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: stray words with no open block
    for (int i = 0; i < 3; i++) cyc(1, 0, 16'hABCD, 3, 0);
    idle(4);
    chk(ready === 1'b1, "R9", "ready after stray words", int'(ready), 1);
    chk(n_done == 0, "R9", "done count after stray words", n_done, 0);

    // full t=8 block, then hold while stray words arrive
    send_block(8, 0, -1);
    chk(blk_words == 263, "R3", "words for t=8", blk_words, 263);
    wait_done();
    cap = syn;
    for (int i = 0; i < 20; i++) cyc(1, 0, 16'h5A5A, 1, 0);
    chk(syn == cap, "R7", "syndromes held", int'(syn != cap), 0);
    chk(n_done == 1, "R5", "done count", n_done, 1);

    // t=2: upper fields masked
    send_block(2, 0, -1);
    chk(blk_words == 258, "R3", "words for t=2", blk_words, 258);
    wait_done();
    chk(syn[NS*GM-1:4*GM] == '0, "R4", "fields above 2t", int'(syn[NS*GM-1:4*GM] != '0), 0);

    // t=0 selects T_MAX
    send_block(0, 0, -1);
    chk(blk_words == 263, "R4", "words for t=0", blk_words, 263);
    wait_done();

    // error-free (all-zero) block
    send_block(5, 1, -1);
    wait_done();
    chk(zero === 1'b1, "R6", "zero_o on clean block", int'(zero), 1);

    // back-to-back blocks: last bit and next start share an edge
    nd = n_done;
    send_block(3, 0, -1);
    send_block(1, 0, -1);
    chk(blk_words == 257, "R3", "words for t=1", blk_words, 257);
    wait_done();
    chk(n_done == nd + 2, "R7", "done count back-to-back", n_done, nd + 2);

    // abort mid-block with a start word offered
    nd = n_done;
    send_block(4, 0, 40);
    cyc(1, 1, 16'h1234, 4, 1);
    chk(ready === 1'b1, "R8", "ready after abort", int'(ready), 1);
    chk(zero === 1'b0, "R8", "zero after abort", int'(zero), 0);
    idle(40);
    chk(n_done == nd, "R8", "no done after abort", n_done, nd);

    // abort coinciding with the last bit
    send_block(6, 0, -1);
    while (!(m_sh == 1 && m_lastw)) idle(1);
    cyc(0, 0, 16'h0, 0, 1);
    idle(20);
    chk(n_done == nd, "R8", "no done when abort hits last bit", n_done, nd);

    // restart by a new start word mid-block
    send_block(7, 0, 30);
    send_block(2, 0, -1);
    wait_done();
    idle(3);
    chk(n_done == nd + 1, "R9", "single done after restart", n_done, nd + 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired (cycle %0d)", cyc_n);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule